// File: doc/BRIEF.md
# Machine-Cycle Clock Mode Controller

This block turns the oscillator clock of an 8-bit microcontroller core into machine-cycle timing. A machine cycle lasts either 12 or 6 oscillator clocks. Software picks the length through bit 0 of a clock-control register. A non-volatile override input can force the short cycle whatever that bit holds. Once per machine cycle the block emits a one-clock strobe. It also emits a faster enable that scales with the same mode, for the serial port's fixed-rate modes. The timer-driven serial modes take their rate elsewhere and do not use this enable.

The external reset pin first passes through a two-flop synchronizer. The block accepts reset only after the synchronized pin has stayed high for two whole machine cycles of the length currently in force. Shorter pulses are dropped. While core reset is asserted, the clock-control register is forced to its reset value and the strobe keeps running. When core reset is released, the block samples the external-access strap and holds that value until the next release.

The design is built from two state machines. The divider has states DIV_SLOW and DIV_FAST. It moves DIV_SLOW→DIV_FAST or DIV_FAST→DIV_SLOW only on the last clock of a machine cycle, and only if the requested mode differs from the current one. The reset qualifier has states RQ_RUN, RQ_QUAL and RQ_HOLD:
- RQ_RUN→RQ_QUAL when the synchronized pin goes high.
- RQ_QUAL→RQ_RUN when the pin drops early.
- RQ_QUAL→RQ_HOLD when the high-time count reaches the limit.
- RQ_HOLD→RQ_RUN when the pin falls, which also samples the strap.
- After power-on the qualifier starts in RQ_HOLD.

Top module: `mcyc_clock_ctrl`

## Requirements
- R1: After power-on, and again after any core reset, the register at address 0x8F reads 0x00, the block runs 12-clock machine cycles, and core_rst stays high from power-on until the reset pin is seen low.
- R2: The register answers only at address 0x8F. A write there stores data bit 0, which reads back in bit 0. Reads at any other address return 0x00, and writes to other addresses change nothing.
- R3: Register bits 7 to 1 ignore written data and always read 0.
- R4: With the override low, mcyc_stb is high for one clock in every 12 when bit 0 is 0, and for one clock in every 6 when bit 0 is 1.
- R5: With otp_x2 high, machine cycles are 6 clocks long whatever bit 0 holds, and bit 0 still reads back the value last written.
- R6: A mode change takes effect only at the next machine-cycle boundary. The cycle in progress finishes at its old length.
- R7: ser_fixed_en is high on every clock in 6-clock mode. In 12-clock mode it is high on alternate clocks, 6 times per machine cycle, including the strobe clock.
- R8: core_rst rises only after the synchronized reset pin has been high for 2 machine cycles of the active length: 12 clocks in 6-clock mode, 24 clocks in 12-clock mode. Shorter pulses leave core_rst low and the register unchanged.
- R9: After the reset pin has been low for two consecutive clock edges, core_rst falls at the next edge.
- R10: ea_latched takes the value of ea_pin at the edge where core_rst falls, and ignores every later change on ea_pin.
- R11: While core_rst is high, register writes are ignored and mcyc_stb keeps its 12-clock spacing unless the override is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| ea_pin | input | 1 | External-access strap pin |
| otp_x2 | input | 1 | Non-volatile override; 1 forces 6-clock cycles |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rd_data | output | 8 | Register read data (combinational) |
| mcyc_stb | output | 1 | One-clock strobe on the last clock of each machine cycle |
| ser_fixed_en | output | 1 | Timing enable for the fixed-rate serial modes |
| fast_mode | output | 1 | 1 while machine cycles are 6 clocks long |
| core_rst | output | 1 | Qualified synchronous reset to the core |
| ea_latched | output | 1 | Held external-access strap value |

## Verification
The bound checker watches these properties on every cycle:
- strobe spacing is always 6 or 12 clocks;
- fast_mode changes only on a strobe clock;
- the override forces the short cycle;
- the reserved read bits stay zero;
- no reset is accepted before 12 raw high clocks;
- core reset releases on time;
- the latched strap stays stable outside a release.

Only the bench's scenarios can show the rest:
- the exact 11-versus-16 and 23-versus-28 clock pulse thresholds, which depend on the active mode;
- the 12, 6, 6 sequence across a mid-cycle mode write;
- the register values seen across resets;
- the strap value captured at each release.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    typedef enum logic {
        DIV_SLOW = 1'b0,
        DIV_FAST = 1'b1
    } div_state_e;

    typedef enum logic [1:0] {
        RQ_RUN  = 2'd0,
        RQ_QUAL = 2'd1,
        RQ_HOLD = 2'd2
    } rq_state_e;

endpackage

// File: rtl/mcyc_divider.sv
module mcyc_divider
    import mcyc_pkg::*;
#(
    parameter int FAST_DIV = 6,
    parameter int SLOW_DIV = 12
) (
    input  logic clk,
    input  logic por_n,
    input  logic mode_req,
    output logic mcyc_stb,
    output logic ser_en,
    output logic fast_mode
);
    localparam int CNT_W = $clog2(SLOW_DIV);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);

    div_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             wrap;

    always_comb begin
        last_cnt = (st_q == DIV_FAST) ? FAST_LAST : SLOW_LAST;
        wrap     = (cnt_q == last_cnt);
    end

    // next-state: mode may only switch on the last clock of a cycle
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DIV_SLOW: if (wrap && mode_req)  st_d = DIV_FAST;
            DIV_FAST: if (wrap && !mode_req) st_d = DIV_SLOW;
            default:  st_d = DIV_SLOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= DIV_SLOW;
        end else begin
            st_q <= st_d;
        end
    end

    // phase counter within the machine cycle
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        mcyc_stb  = wrap;
        fast_mode = (st_q == DIV_FAST);
        ser_en    = fast_mode ? 1'b1 : cnt_q[0];
    end

endmodule

// File: rtl/mcyc_rst_qual.sv
module mcyc_rst_qual
    import mcyc_pkg::*;
#(
    parameter int FAST_DIV    = 6,
    parameter int SLOW_DIV    = 12,
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic ea_pin,
    input  logic fast_mode,
    output logic core_rst,
    output logic ea_latched
);
    localparam int QCNT_W = $clog2(QUAL_CYCLES * SLOW_DIV + 1);
    localparam logic [QCNT_W-1:0] FAST_NEED_M1 = QCNT_W'(QUAL_CYCLES * FAST_DIV - 1);
    localparam logic [QCNT_W-1:0] SLOW_NEED_M1 = QCNT_W'(QUAL_CYCLES * SLOW_DIV - 1);

    rq_state_e         st_q, st_d;
    logic [1:0]        sync_q;
    logic              pin_hi;
    logic [QCNT_W-1:0] hi_cnt_q;
    logic [QCNT_W-1:0] need_m1;
    logic              ea_q;

    // two-flop synchronizer, reset to "pin high"
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], rst_pin};
        end
    end

    always_comb begin
        pin_hi  = sync_q[1];
        need_m1 = fast_mode ? FAST_NEED_M1 : SLOW_NEED_M1;
    end

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RQ_RUN:  if (pin_hi) st_d = RQ_QUAL;
            RQ_QUAL: begin
                if (!pin_hi)                  st_d = RQ_RUN;
                else if (hi_cnt_q >= need_m1) st_d = RQ_HOLD;
            end
            RQ_HOLD: if (!pin_hi) st_d = RQ_RUN;
            default: st_d = RQ_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= RQ_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    // high-time counter: cleared whenever the synchronized pin is low
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hi_cnt_q <= '0;
        end else if (!pin_hi) begin
            hi_cnt_q <= '0;
        end else if (st_q == RQ_RUN) begin
            hi_cnt_q <= QCNT_W'(1);
        end else if (st_q == RQ_QUAL) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end else begin
            hi_cnt_q <= '0;
        end
    end

    // strap capture on the release transition
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ea_q <= 1'b0;
        end else if ((st_q == RQ_HOLD) && (st_d == RQ_RUN)) begin
            ea_q <= ea_pin;
        end
    end

    // outputs
    always_comb begin
        core_rst   = (st_q == RQ_HOLD);
        ea_latched = ea_q;
    end

endmodule

// File: rtl/mcyc_sfr.sv
module mcyc_sfr #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h8F
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              core_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              x2_bit
);
    logic hit;
    logic x2_q;
    logic unused_rsv;

    always_comb begin
        hit        = (addr == SFR_ADDR);
        unused_rsv = ^wdata[DATA_W-1:1];
        rdata      = hit ? {{(DATA_W-1){1'b0}}, x2_q} : '0;
        x2_bit     = x2_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            x2_q <= 1'b0;
        end else if (core_rst) begin
            x2_q <= 1'b0;
        end else if (wr && hit) begin
            x2_q <= wdata[0];
        end
    end

endmodule

// File: rtl/mcyc_clock_ctrl.sv
module mcyc_clock_ctrl #(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] SFR_ADDR    = 8'h8F,
    parameter int                FAST_DIV    = 6,
    parameter int                SLOW_DIV    = 12,
    parameter int                QUAL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin,
    input  logic              ea_pin,
    input  logic              otp_x2,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rd_data,
    output logic              mcyc_stb,
    output logic              ser_fixed_en,
    output logic              fast_mode,
    output logic              core_rst,
    output logic              ea_latched
);
    logic x2_bit;
    logic mode_req;

    always_comb mode_req = otp_x2 | x2_bit;

    mcyc_sfr #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SFR_ADDR(SFR_ADDR)
    ) u_sfr (
        .clk     (clk),
        .por_n   (por_n),
        .core_rst(core_rst),
        .addr    (sfr_addr),
        .wr      (sfr_wr),
        .wdata   (sfr_wdata),
        .rdata   (sfr_rd_data),
        .x2_bit  (x2_bit)
    );

    mcyc_divider #(
        .FAST_DIV(FAST_DIV),
        .SLOW_DIV(SLOW_DIV)
    ) u_div (
        .clk      (clk),
        .por_n    (por_n),
        .mode_req (mode_req),
        .mcyc_stb (mcyc_stb),
        .ser_en   (ser_fixed_en),
        .fast_mode(fast_mode)
    );

    mcyc_rst_qual #(
        .FAST_DIV   (FAST_DIV),
        .SLOW_DIV   (SLOW_DIV),
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_qual (
        .clk       (clk),
        .por_n     (por_n),
        .rst_pin   (rst_pin),
        .ea_pin    (ea_pin),
        .fast_mode (fast_mode),
        .core_rst  (core_rst),
        .ea_latched(ea_latched)
    );

endmodule

// File: rtl/mcyc_clock_ctrl_chk.sv
module mcyc_clock_ctrl_chk #(
    parameter int DATA_W      = 8,
    parameter int FAST_DIV    = 6,
    parameter int SLOW_DIV    = 12,
    parameter int QUAL_CYCLES = 2
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_pin,
    input logic              otp_x2,
    input logic [DATA_W-2:0] rsv_bits,
    input logic              mcyc_stb,
    input logic              ser_fixed_en,
    input logic              fast_mode,
    input logic              core_rst,
    input logic              ea_latched
);
    localparam int GAP_W = $clog2(SLOW_DIV + 1);
    localparam int PH_W  = $clog2(QUAL_CYCLES * SLOW_DIV + 4);
    localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    logic [PH_W-1:0]  ph_q;
    logic [1:0]       age_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            ph_q   <= '0;
            age_q  <= '0;
        end else begin
            if (mcyc_stb) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q != GAP_W'(SLOW_DIV)) begin
                gap_q <= gap_q + 1'b1;
            end
            if (!rst_pin)          ph_q <= '0;
            else if (ph_q != PH_MAX) ph_q <= ph_q + 1'b1;
            if (age_q != 2'd3) age_q <= age_q + 1'b1;
        end
    end

    AST_STB_SPACING: assert property (@(posedge clk) disable iff (!por_n)
        (seen_q && mcyc_stb) |-> (gap_q == GAP_W'(FAST_DIV - 1) || gap_q == GAP_W'(SLOW_DIV - 1))); // R4

    AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!por_n)
        !mcyc_stb |=> $stable(fast_mode)); // R6

    AST_OTP_FORCES_FAST: assert property (@(posedge clk) disable iff (!por_n)
        (mcyc_stb && otp_x2) |=> fast_mode); // R5

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        rsv_bits == '0); // R3

    AST_SER_FAST: assert property (@(posedge clk) disable iff (!por_n)
        fast_mode |-> ser_fixed_en); // R7

    AST_RST_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst) |-> (ph_q >= PH_W'(QUAL_CYCLES * FAST_DIV))); // R8

    AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        (age_q == 2'd3 && core_rst && !rst_pin && !$past(rst_pin) && !$past(rst_pin, 2)) |=> !core_rst); // R9

    AST_EA_HELD: assert property (@(posedge clk) disable iff (!por_n)
        !$fell(core_rst) |-> $stable(ea_latched)); // R10

    AST_RST_CLEARS_MODE: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst && $past(core_rst) && mcyc_stb && !otp_x2) |=> !fast_mode); // R11

endmodule

bind mcyc_clock_ctrl mcyc_clock_ctrl_chk #(
    .DATA_W     (DATA_W),
    .FAST_DIV   (FAST_DIV),
    .SLOW_DIV   (SLOW_DIV),
    .QUAL_CYCLES(QUAL_CYCLES)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_pin     (rst_pin),
    .otp_x2      (otp_x2),
    .rsv_bits    (sfr_rd_data[DATA_W-1:1]),
    .mcyc_stb    (mcyc_stb),
    .ser_fixed_en(ser_fixed_en),
    .fast_mode   (fast_mode),
    .core_rst    (core_rst),
    .ea_latched  (ea_latched)
);

// File: tb/mcyc_clock_ctrl_bench.sv
module mcyc_clock_ctrl_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_pin = 1'b1;
    logic       ea_pin = 1'b1;
    logic       otp_x2 = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rd_data;
    logic       mcyc_stb, ser_fixed_en, fast_mode, core_rst, ea_latched;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string mon_tag = "R4";
    int    iv = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    mcyc_clock_ctrl u_mcyc_clock_ctrl (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .ea_pin(ea_pin),
        .otp_x2(otp_x2), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rd_data(sfr_rd_data),
        .mcyc_stb(mcyc_stb), .ser_fixed_en(ser_fixed_en),
        .fast_mode(fast_mode), .core_rst(core_rst), .ea_latched(ea_latched)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the expected machine-cycle length on each strobe
    always @(negedge clk) begin
        if (por_n) begin
            iv++;
            if (mcyc_stb) begin
                if (exp_q.size() > 0) check(mon_tag, iv, exp_q.pop_front());
                iv = 0;
            end
        end
    end

    task automatic sync_stb();
        @(negedge clk);
        while (!mcyc_stb) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic expect_gaps(input string tag, input int len, input int n);
        sync_stb();
        mon_tag = tag;
        for (int i = 0; i < n; i++) exp_q.push_back(len);
        drain();
    endtask

    task automatic wr_sfr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd_sfr(input logic [7:0] a, output int d);
        @(negedge clk);
        sfr_addr = a;
        #1 d = int'(sfr_rd_data);
    endtask

    task automatic count_ser(output int c);
        c = 0;
        sync_stb();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (ser_fixed_en) c++;
        end
    endtask

    // pin high for n clocks, then low; reports whether core_rst was seen high
    task automatic pulse_rst(input int n, output int saw);
        saw = 0;
        @(negedge clk);
        rst_pin = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core_rst) saw = 1;
        end
        rst_pin = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (core_rst) saw = 1;
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int d;
        int c;
        int saw;
        repeat (4) @(negedge clk);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 core_rst at power-up", int'(core_rst), 1);
        rd_sfr(8'h8F, d);
        check("R1 reg after power-up", d, 0);
        check("R1 slow mode after power-up", int'(fast_mode), 0);

        // release: strap sampled high
        @(negedge clk); rst_pin = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check("R9 core_rst released", int'(core_rst), 0);
        check("R10 strap captured", int'(ea_latched), 1);
        ea_pin = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        check("R10 strap held after pin change", int'(ea_latched), 1);

        expect_gaps("R4 slow spacing", 12, 3);
        count_ser(c);
        check("R7 ser enable slow mode", c, 6);

        // mid-cycle write: old length completes first
        sync_stb();
        wr_sfr(8'h8F, 8'hFF);
        mon_tag = "R6 boundary switch";
        exp_q.push_back(12); exp_q.push_back(6); exp_q.push_back(6);
        drain();
        rd_sfr(8'h8F, d);
        check("R3 reserved bits read zero", d, 1);
        wr_sfr(8'h8E, 8'h00);
        rd_sfr(8'h8F, d);
        check("R2 other address write ignored", d, 1);
        rd_sfr(8'h8E, d);
        check("R2 other address reads zero", d, 0);
        expect_gaps("R4 fast spacing", 6, 3);
        count_ser(c);
        check("R7 ser enable fast mode", c, 12);

        // qualification in 6-clock mode: 12 clocks needed
        pulse_rst(11, saw);
        check("R8 short pulse fast mode", saw, 0);
        rd_sfr(8'h8F, d);
        check("R8 register kept after short pulse", d, 1);
        pulse_rst(16, saw);
        check("R8 long pulse fast mode", saw, 1);

        // held reset: writes ignored, strobe continues at 12
        @(negedge clk); rst_pin = 1'b1;
        repeat (40) @(negedge clk);
        #1;
        check("R11 core_rst held", int'(core_rst), 1);
        wr_sfr(8'h8F, 8'h01);
        rd_sfr(8'h8F, d);
        check("R11 write ignored in reset", d, 0);
        expect_gaps("R11 strobe runs in reset", 12, 2);
        @(negedge clk); rst_pin = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        check("R10 strap recaptured low", int'(ea_latched), 0);
        rd_sfr(8'h8F, d);
        check("R1 reg after core reset", d, 0);
        check("R1 slow mode after core reset", int'(fast_mode), 0);

        // qualification in 12-clock mode: 24 clocks needed
        pulse_rst(16, saw);
        check("R8 16 clocks slow mode", saw, 0);
        pulse_rst(23, saw);
        check("R8 23 clocks slow mode", saw, 0);
        pulse_rst(28, saw);
        check("R8 28 clocks slow mode", saw, 1);

        // override
        otp_x2 = 1'b1;
        sync_stb();
        expect_gaps("R5 override forces fast", 6, 3);
        rd_sfr(8'h8F, d);
        check("R5 bit0 unaffected by override", d, 0);
        wr_sfr(8'h8F, 8'h01);
        wr_sfr(8'h8F, 8'h00);
        expect_gaps("R5 override with bit0 cleared", 6, 2);
        otp_x2 = 1'b0;
        sync_stb();
        expect_gaps("R5 override removed", 12, 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule